// File: doc/BRIEF.md
# Prioritized Interrupt-to-Thread Controller

This block gathers a set of external interrupt lines, by default 32, and drives the single interrupt request of a multithreaded processor. Each line is captured on its rising edge into a pending bit. A per-line enable mask decides which pending bits may compete. Among the competing bits, the lowest bit index wins, so line 0 has the highest priority and the last line has the lowest.

An accepted interrupt does not jump to a vector. When the processor acknowledges the current winner, the block clears that one pending bit. In the next cycle it issues a single-cycle enqueue request that carries a service thread ID and the top scheduling priority. It raises a slice-preempt pulse in the same cycle, which ends the running thread's time slice early. The service thread ID is a fixed base ID plus the winning vector index. The scheduler queues and the service code sit outside the block.

Top module: `irq_thread_ctrl`

## Requirements
- R1: A pending bit is set only by a low-to-high transition of its line. A line held high after its interrupt has been accepted does not become pending again.
- R2: The winning line is the enabled pending line with the lowest index, so line 0 has the highest priority and line 31 the lowest.
- R3: `irq_req` is high exactly when at least one enabled line is pending. `irq_vector` then gives the index of the winner.
- R4: `irq_ack` sampled high while `irq_req` is high produces `enq_valid` high for exactly one cycle in the following cycle. `enq_prio` is 0 in that cycle, where 0 encodes the top scheduling priority.
- R5: During an enqueue, `enq_tid` equals ISR_BASE_ID (default 0x40) plus the vector index that was acknowledged.
- R6: `slice_preempt` pulses in exactly the cycles in which `enq_valid` is high. An `irq_ack` while `irq_req` is low produces neither pulse.
- R7: A pending line whose enable bit is 0 takes no part in the request or the priority selection, but it stays pending. It competes once its enable bit is set.
- R8: An acknowledge clears only the winner's pending bit. Other pending enabled lines keep `irq_req` high, and the next one in priority order becomes the winner.
- R9: After reset no line is pending and `irq_req`, `enq_valid` and `slice_preempt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_lines | input | 32 | External interrupt lines, captured on rising edges |
| irq_enable | input | 32 | Per-line enable mask, 1 allows the line to compete |
| irq_ack | input | 1 | Processor accepts the current winner |
| irq_req | output | 1 | Combined interrupt request toward the processor |
| irq_vector | output | 5 | Index of the winning line |
| enq_valid | output | 1 | One-cycle enqueue strobe toward the scheduler |
| enq_tid | output | 8 | Service thread ID for the enqueue |
| enq_prio | output | 2 | Scheduling priority of the enqueue, 0 is top |
| slice_preempt | output | 1 | Ends the running time slice early |

## Verification
On every cycle the assertions check that an enqueue follows each acknowledged request in the next cycle with the right thread ID and top priority. They also check that no enqueue or preempt pulse appears without an acknowledged request, that the preempt pulse always coincides with the enqueue, and that a reported winner is always enabled. Several behaviours can only be shown by the bench's scenarios, because they depend on the hidden pending state. These are the priority order among simultaneous lines (including the line 30 and line 31 boundary), the survival of other pending bits after an acknowledge, the refusal to re-pend a line held high, and a masked line that stays pending until it is enabled.

// File: rtl/irq_thread_pkg.sv
package irq_thread_pkg;
  localparam int unsigned PRIO_W   = 2;
  localparam logic [PRIO_W-1:0] PRIO_TOP = '0;

  typedef struct packed {
    logic             valid;
    logic [7:0]       tid;
  } enq_req_t;
endpackage

// File: rtl/irq_edge_pending.sv
module irq_edge_pending #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] clear_i,
  output logic [NUM_LINES-1:0] pending_o
);
  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] rise;

  // A fresh edge in the same cycle as a clear wins: the new event is kept.
  always_comb begin
    rise   = lines_i & ~line_q;
    pend_d = (pend_q & ~clear_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= lines_i;
      pend_q <= pend_d;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned VEC_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] pending_i,
  input  logic [NUM_LINES-1:0] enable_i,
  output logic                 any_o,
  output logic [VEC_W-1:0]     index_o,
  output logic [NUM_LINES-1:0] grant_o
);
  logic [NUM_LINES-1:0] live;
  logic [NUM_LINES:0]   below;

  assign live     = pending_i & enable_i;
  assign below[0] = 1'b0;

  // Ripple chain: a line wins when it is live and no lower index is live.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chain
    assign grant_o[g]  = live[g] & ~below[g];
    assign below[g+1]  = below[g] | live[g];
  end

  assign any_o = below[NUM_LINES];

  always_comb begin
    index_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grant_o[i]) index_o = index_o | VEC_W'(i);
    end
  end
endmodule

// File: rtl/irq_enq_issuer.sv
module irq_enq_issuer #(
  parameter int unsigned VEC_W       = 5,
  parameter int unsigned TID_W       = 8,
  parameter logic [TID_W-1:0] ISR_BASE_ID = 8'h40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept_i,
  input  logic [VEC_W-1:0]              vector_i,
  output logic                          enq_valid_o,
  output logic [TID_W-1:0]              enq_tid_o,
  output logic [irq_thread_pkg::PRIO_W-1:0] enq_prio_o,
  output logic                          preempt_o
);
  logic             valid_q, valid_d;
  logic             pre_q, pre_d;
  logic [TID_W-1:0] tid_q, tid_d;
  logic             tid_en;

  always_comb begin
    valid_d = accept_i;
    pre_d   = accept_i;
    tid_en  = accept_i;
    tid_d   = ISR_BASE_ID + TID_W'(vector_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pre_q   <= 1'b0;
      tid_q   <= '0;
    end else begin
      valid_q <= valid_d;
      pre_q   <= pre_d;
      if (tid_en) tid_q <= tid_d;
    end
  end

  assign enq_valid_o = valid_q;
  assign preempt_o   = pre_q;
  assign enq_tid_o   = tid_q;
  assign enq_prio_o  = irq_thread_pkg::PRIO_TOP;
endmodule

// File: rtl/irq_thread_ctrl.sv
module irq_thread_ctrl #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned TID_W       = 8,
  parameter logic [TID_W-1:0] ISR_BASE_ID = 8'h40,
  localparam int unsigned VEC_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_LINES-1:0] irq_enable,
  input  logic                 irq_ack,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vector,
  output logic                 enq_valid,
  output logic [TID_W-1:0]     enq_tid,
  output logic [irq_thread_pkg::PRIO_W-1:0] enq_prio,
  output logic                 slice_preempt
);
  logic [1:0]           rst_pipe;
  logic                 rst_ns;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] grant;
  logic [NUM_LINES-1:0] clear;
  logic                 accept;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  irq_edge_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_ns),
    .lines_i   (irq_lines),
    .clear_i   (clear),
    .pending_o (pending)
  );

  irq_prio_select #(.NUM_LINES(NUM_LINES)) u_sel (
    .pending_i (pending),
    .enable_i  (irq_enable),
    .any_o     (irq_req),
    .index_o   (irq_vector),
    .grant_o   (grant)
  );

  always_comb begin
    accept = irq_ack & irq_req;
    clear  = accept ? grant : '0;
  end

  irq_enq_issuer #(.VEC_W(VEC_W), .TID_W(TID_W), .ISR_BASE_ID(ISR_BASE_ID)) u_enq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .accept_i    (accept),
    .vector_i    (irq_vector),
    .enq_valid_o (enq_valid),
    .enq_tid_o   (enq_tid),
    .enq_prio_o  (enq_prio),
    .preempt_o   (slice_preempt)
  );
endmodule

// File: rtl/irq_thread_ctrl_chk.sv
module irq_thread_ctrl_chk #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned TID_W       = 8,
  parameter logic [TID_W-1:0] ISR_BASE_ID = 8'h40,
  localparam int unsigned VEC_W      = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_enable,
  input logic                 irq_ack,
  input logic                 irq_req,
  input logic [VEC_W-1:0]     irq_vector,
  input logic                 enq_valid,
  input logic [TID_W-1:0]     enq_tid,
  input logic [1:0]           enq_prio,
  input logic                 slice_preempt
);
  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_enable[irq_vector]); // R3 R7

  AST_ENQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (enq_valid && enq_tid == ISR_BASE_ID + TID_W'($past(irq_vector)))); // R5

  AST_NO_SPURIOUS_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_req) |=> !enq_valid); // R4

  AST_PREEMPT_WITH_ENQ: assert property (@(posedge clk) disable iff (!rst_n)
    slice_preempt == enq_valid); // R6

  AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |-> enq_prio == 2'd0); // R4
endmodule

bind irq_thread_ctrl irq_thread_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .TID_W(TID_W), .ISR_BASE_ID(ISR_BASE_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable), .irq_ack(irq_ack),
  .irq_req(irq_req), .irq_vector(irq_vector), .enq_valid(enq_valid),
  .enq_tid(enq_tid), .enq_prio(enq_prio), .slice_preempt(slice_preempt)
);

// File: tb/sim_irq_thread_ctrl.sv
`timescale 1ns/1ps
module sim_irq_thread_ctrl;
  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [31:0] irq_enable = '1;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [4:0]  irq_vector;
  logic        enq_valid;
  logic [7:0]  enq_tid;
  logic [1:0]  enq_prio;
  logic        slice_preempt;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  irq_thread_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .irq_enable(irq_enable),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector),
    .enq_valid(enq_valid), .enq_tid(enq_tid), .enq_prio(enq_prio),
    .slice_preempt(slice_preempt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: acknowledge the current winner, push the expected enqueue.
  task automatic accept(input string req, input int vec);
    check(req, {31'd0, irq_req}, 32'd1);
    check(req, {27'd0, irq_vector}, vec);
    exp_q.push_back(BASE + 8'(vec));
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // Monitor: every enqueue must match the oldest expected item.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 preempt", {31'd0, slice_preempt}, {31'd0, enq_valid});
      if (enq_valid) begin
        if (exp_q.size() == 0) check("R4 unexpected enqueue", 32'd1, 32'd0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check("R5 tid", {24'd0, enq_tid}, {24'd0, e});
          check("R4 prio", {30'd0, enq_prio}, 32'd0);
        end
      end
    end
  end

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 req", {31'd0, irq_req}, 32'd0);
    check("R9 enq", {31'd0, enq_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 req after release", {31'd0, irq_req}, 32'd0);

    // R6: ack with nothing pending does nothing
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R6 idle ack", {31'd0, enq_valid}, 32'd0);

    // R3 R5: single line
    irq_lines[5] = 1'b1; @(negedge clk);
    accept("R3 single", 5);
    irq_lines[5] = 1'b0; @(negedge clk);
    check("R3 cleared", {31'd0, irq_req}, 32'd0);

    // R2 R8: simultaneous lines, served by index, others persist
    irq_lines = 32'h0000_0089; @(negedge clk);
    accept("R2 first", 0);
    accept("R8 second", 3);
    accept("R8 third", 7);
    // R1: levels still high, no re-pend
    @(negedge clk);
    check("R1 held level", {31'd0, irq_req}, 32'd0);
    irq_lines = '0; @(negedge clk);

    // R2 boundary: 31 loses to 30
    irq_lines = 32'hC000_0000; @(negedge clk);
    accept("R2 line30", 30);
    accept("R2 line31", 31);
    irq_lines = '0; @(negedge clk);

    // R1: new edge after release re-pends
    irq_lines[12] = 1'b1; @(negedge clk);
    accept("R1 edge", 12);
    irq_lines[12] = 1'b0; @(negedge clk);
    irq_lines[12] = 1'b1; @(negedge clk);
    accept("R1 re-edge", 12);
    irq_lines[12] = 1'b0; @(negedge clk);

    // R7: masked line stays pending
    irq_enable[9] = 1'b0;
    irq_lines[9] = 1'b1; @(negedge clk);
    check("R7 masked req", {31'd0, irq_req}, 32'd0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    check("R7 masked ack", {31'd0, enq_valid}, 32'd0);
    irq_lines[9] = 1'b0;
    repeat (2) @(negedge clk);
    irq_enable[9] = 1'b1; @(negedge clk);
    accept("R7 enabled", 9);
    @(negedge clk);
    check("R3 idle end", {31'd0, irq_req}, 32'd0);
    check("R4 queue drained", exp_q.size(), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule